// File: doc/BRIEF.md
# Saturating Four-Input Neuron

This block is a single artificial neuron with no clock. It multiplies four signed 8-bit data values by four signed 8-bit weights and adds the products together with a signed 8-bit bias in one multi-operand addition. The accumulator is wide enough that the sum never wraps. A separate activation stage then clamps the full-width sum to a 16-bit signed fractional output.

Data and weights are read as fractions with 7 fraction bits, so each 16-bit product carries 14 fraction bits. The bias uses the same 7-fraction-bit format. It is sign-extended and shifted left by 7 so that its binary point matches the products before it joins the sum. Weights and bias come in on ports, and the block holds no state. The output is therefore a pure function of the present inputs, and a larger design can use it wherever a neuron evaluation is needed.

Top module: `saturating_neuron`

## Requirements
- R1: Each lane product is the signed product of data lane i and weight lane i. Lane i occupies bits [8i+7:8i] of its packed port, and every value is two's complement.
- R2: The bias is sign-extended and multiplied by 128 (shifted left by 7) before it is added. With all products zero, a bias of 1 gives 0x0080 and a bias of -1 gives 0xFF80.
- R3: If the signed total of the four products plus the aligned bias lies in [-32768, 32767], the output equals that total as 16-bit two's complement.
- R4: If the total is above 32767, the output is 0x7FFF.
- R5: If the total is below -32768, the output is 0x8000.
- R6: The clamp edges are exact: 32767 and -32768 pass unchanged, while 32768 gives 0x7FFF and -32769 gives 0x8000.
- R7: The block holds no state. When the inputs change on every cycle, the output of each cycle reflects only that cycle's inputs.
- R8: The accumulator never wraps. At the extreme input values the total stays within ±81920, so very large sums clamp to the correct rail and never fold over to the other sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| x_flat | input | 32 | Four packed signed data lanes, lane i at [8i+7:8i] |
| w_flat | input | 32 | Four packed signed weight lanes, lane i at [8i+7:8i] |
| bias | input | 8 | Signed bias, 7 fraction bits |
| y | output | 16 | Saturated signed fractional result |

## Verification
The checker assumes that all inputs are driven to known values once the bench begins applying vectors. It also assumes that every input combination is legal, so that any 8-bit pattern on any lane is valid stimulus. The bench honours both assumptions: it drives every port on each cycle from the first one onward, and its random vectors cover the full two's complement range of each lane. Directed vectors add the extreme rails and sums placed exactly on both clamp edges, so the pass-through and clamp properties are each exercised on both sides of each limit.

// File: rtl/neuron_pkg.sv
package neuron_pkg;
    localparam int unsigned NRN_DATA_W = 8;
    localparam int unsigned NRN_N_IN   = 4;
    localparam int unsigned NRN_OUT_W  = 16;
endpackage

// File: rtl/nrn_mul_bank.sv
module nrn_mul_bank #(
    parameter int unsigned DATA_W = neuron_pkg::NRN_DATA_W,
    parameter int unsigned N_IN   = neuron_pkg::NRN_N_IN,
    localparam int unsigned PROD_W = 2 * DATA_W
) (
    input  logic [N_IN*DATA_W-1:0] x_flat,
    input  logic [N_IN*DATA_W-1:0] w_flat,
    output logic [N_IN*PROD_W-1:0] p_flat
);
    // one signed multiplier per lane
    for (genvar i = 0; i < N_IN; i++) begin : g_lane
        logic signed [DATA_W-1:0] xs;
        logic signed [DATA_W-1:0] ws;
        logic signed [PROD_W-1:0] prod;
        assign xs   = x_flat[i*DATA_W +: DATA_W];
        assign ws   = w_flat[i*DATA_W +: DATA_W];
        assign prod = xs * ws;
        assign p_flat[i*PROD_W +: PROD_W] = prod;
    end
endmodule

// File: rtl/nrn_sum.sv
module nrn_sum #(
    parameter int unsigned DATA_W = neuron_pkg::NRN_DATA_W,
    parameter int unsigned N_IN   = neuron_pkg::NRN_N_IN,
    localparam int unsigned PROD_W = 2 * DATA_W,
    localparam int unsigned ACC_W  = PROD_W + $clog2(N_IN),
    localparam int unsigned SHIFT  = DATA_W - 1
) (
    input  logic [N_IN*PROD_W-1:0]    p_flat,
    input  logic [DATA_W-1:0]         bias,
    output logic signed [ACC_W-1:0]   acc
);
    logic signed [ACC_W-1:0] bias_al;

    // sign-extend, then move binary point to product format
    assign bias_al = {{(ACC_W-DATA_W-SHIFT){bias[DATA_W-1]}}, bias, {SHIFT{1'b0}}};

    // single multi-operand sum, written as one unrolled expression
    always_comb begin
        acc = bias_al;
        for (int i = 0; i < int'(N_IN); i++) begin
            acc = acc + {{(ACC_W-PROD_W){p_flat[i*PROD_W+PROD_W-1]}},
                         p_flat[i*PROD_W +: PROD_W]};
        end
    end
endmodule

// File: rtl/nrn_clamp.sv
module nrn_clamp #(
    parameter int unsigned ACC_W = 18,
    parameter int unsigned OUT_W = neuron_pkg::NRN_OUT_W,
    localparam int unsigned HI_W = ACC_W - OUT_W
) (
    input  logic signed [ACC_W-1:0] acc,
    output logic [OUT_W-1:0]        y
);
    localparam logic [OUT_W-1:0] RAIL_HI = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] RAIL_LO = {1'b1, {(OUT_W-1){1'b0}}};

    logic [HI_W:0] top_bits;
    logic          over_hi;
    logic          over_lo;

    // bits above the output sign must all equal the accumulator sign
    assign top_bits = acc[ACC_W-1 : OUT_W-1];
    assign over_hi  = ~acc[ACC_W-1] & (|top_bits);
    assign over_lo  =  acc[ACC_W-1] & ~(&top_bits);

    always_comb begin
        if (over_hi)      y = RAIL_HI;
        else if (over_lo) y = RAIL_LO;
        else              y = acc[OUT_W-1:0];
    end
endmodule

// File: rtl/saturating_neuron.sv
module saturating_neuron #(
    parameter int unsigned DATA_W = neuron_pkg::NRN_DATA_W,
    parameter int unsigned N_IN   = neuron_pkg::NRN_N_IN,
    parameter int unsigned OUT_W  = neuron_pkg::NRN_OUT_W,
    localparam int unsigned PROD_W = 2 * DATA_W,
    localparam int unsigned ACC_W  = PROD_W + $clog2(N_IN)
) (
    input  logic [N_IN*DATA_W-1:0] x_flat,
    input  logic [N_IN*DATA_W-1:0] w_flat,
    input  logic [DATA_W-1:0]      bias,
    output logic [OUT_W-1:0]       y
);
    logic [N_IN*PROD_W-1:0]  prod_flat;
    logic signed [ACC_W-1:0] acc_w;

    nrn_mul_bank #(.DATA_W(DATA_W), .N_IN(N_IN)) u_mul (
        .x_flat (x_flat),
        .w_flat (w_flat),
        .p_flat (prod_flat)
    );

    nrn_sum #(.DATA_W(DATA_W), .N_IN(N_IN)) u_sum (
        .p_flat (prod_flat),
        .bias   (bias),
        .acc    (acc_w)
    );

    nrn_clamp #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_act (
        .acc (acc_w),
        .y   (y)
    );
endmodule

// File: rtl/saturating_neuron_chk.sv
module saturating_neuron_chk #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned N_IN   = 4,
    parameter int unsigned OUT_W  = 16,
    parameter int unsigned ACC_W  = 18
) (
    input logic signed [ACC_W-1:0] acc,
    input logic [OUT_W-1:0]        y
);
    localparam int MAXV = (2 ** (OUT_W - 1)) - 1;
    localparam int MINV = -(2 ** (OUT_W - 1));
    localparam int LIM  = (N_IN + 1) * (2 ** (2 * DATA_W - 2));

    always_comb begin
        if (!$isunknown(acc) && !$isunknown(y)) begin
            // R4
            if (int'(acc) > MAXV) begin
                sat_hi_chk: assert (y == OUT_W'(MAXV));
            end
            // R5
            if (int'(acc) < MINV) begin
                sat_lo_chk: assert (y == OUT_W'(MINV));
            end
            // R3
            if (int'(acc) <= MAXV && int'(acc) >= MINV) begin
                pass_thru_chk: assert (y == acc[OUT_W-1:0]);
            end
            // R8
            acc_bound_chk: assert (int'(acc) <= LIM && int'(acc) >= -LIM);
        end
    end
endmodule

bind saturating_neuron saturating_neuron_chk #(
    .DATA_W(DATA_W), .N_IN(N_IN), .OUT_W(OUT_W), .ACC_W(ACC_W)
) u_chk (
    .acc (acc_w),
    .y   (y)
);

// File: tb/saturating_neuron_tb.sv
module saturating_neuron_tb;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [15:0] exp_y;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic [31:0] x_flat = '0;
    logic [31:0] w_flat = '0;
    logic [7:0]  bias = '0;
    logic [15:0] y;

    item_t q[$];
    int total = 0;
    int bad = 0;
    bit done = 0;
    bit drv_done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    saturating_neuron u_dut (
        .x_flat (x_flat),
        .w_flat (w_flat),
        .bias   (bias),
        .y      (y)
    );

    function automatic logic [15:0] model(input int xs[4], input int ws[4], input int b);
        int s = b * 128;
        for (int i = 0; i < 4; i++) s += xs[i] * ws[i];
        if (s > 32767) return 16'h7FFF;
        if (s < -32768) return 16'h8000;
        return s[15:0];
    endfunction

    task automatic drive(input int xs[4], input int ws[4], input int b, input string tag);
        item_t it;
        @(posedge clk);
        #1;
        for (int i = 0; i < 4; i++) begin
            x_flat[i*8 +: 8] = xs[i][7:0];
            w_flat[i*8 +: 8] = ws[i][7:0];
        end
        bias = b[7:0];
        it.exp_y = model(xs, ws, b);
        it.tag = tag;
        q.push_back(it);
    endtask

    // monitor: compare at the falling edge of the cycle the item was driven
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            total++;
            if (y !== it.exp_y) begin
                bad++;
                $display("FAIL %s: y=%h expected=%h", it.tag, y, it.exp_y);
            end
        end
    end

    initial begin
        // reset state equivalent: all-zero inputs give zero (R3)
        drive('{0,0,0,0}, '{0,0,0,0}, 0, "R3 zero");
        // R1 single lanes and signs
        drive('{5,0,0,0}, '{-3,0,0,0}, 0, "R1 lane0");
        drive('{0,0,0,-7}, '{0,0,0,-9}, 0, "R1 lane3");
        drive('{0,-128,0,0}, '{0,-128,0,0}, 0, "R1 minmin");
        drive('{0,0,100,0}, '{0,0,-1,0}, 0, "R1 lane2");
        // R2 bias alignment
        drive('{0,0,0,0}, '{0,0,0,0}, 1, "R2 bias+1");
        drive('{0,0,0,0}, '{0,0,0,0}, -1, "R2 bias-1");
        drive('{0,0,0,0}, '{0,0,0,0}, 127, "R2 bias max");
        drive('{0,0,0,0}, '{0,0,0,0}, -128, "R2 bias min");
        // R3 mixed
        drive('{10,-20,30,-40}, '{3,5,-7,2}, 9, "R3 mixed");
        // R4 / R5 rails
        drive('{127,127,127,127}, '{127,127,127,127}, 0, "R4 high");
        drive('{-128,-128,-128,-128}, '{127,127,127,127}, 0, "R5 low");
        // R6 exact edges
        drive('{-128,127,127,0}, '{-128,127,2,0}, 0, "R6 32767");
        drive('{-128,127,127,1}, '{-128,127,2,1}, 0, "R6 32768");
        drive('{-128,-128,-128,0}, '{127,127,2,0}, 0, "R6 -32768");
        drive('{-128,-128,-128,-1}, '{127,127,2,1}, 0, "R6 -32769");
        // R8 extremes, no wrap
        drive('{-128,-128,-128,-128}, '{-128,-128,-128,-128}, 127, "R8 max");
        drive('{-128,-128,-128,-128}, '{127,127,127,127}, -128, "R8 min");
        // R7 back-to-back changing inputs, random
        for (int n = 0; n < 300; n++) begin
            int xs[4];
            int ws[4];
            int b;
            for (int i = 0; i < 4; i++) begin
                xs[i] = int'($signed(8'($urandom)));
                ws[i] = int'($signed(8'($urandom)));
            end
            b = int'($signed(8'($urandom)));
            drive(xs, ws, b, "R7 random");
        end
        drive('{1,0,0,0}, '{1,0,0,0}, 0, "R7 after random");
        repeat (3) @(posedge clk);
        drv_done = 1;
    end

    initial begin
        wait (drv_done);
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: y=%h expected=finish", y);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule